// File: doc/BRIEF.md
# Decimal Accumulator Processor with Register-Transfer Sequencing

This block is a small multi-cycle processor that works on three-digit decimal values. Every word in its 100-entry internal memory holds a value from 0 to 999. An instruction word is read as one opcode digit (hundreds) followed by a two-digit address (00 to 99). Each state of the control sequence moves data across exactly one path between the program counter, the address latch, the data latch, the instruction latch and a single accumulator. The accumulator holds a sign and a magnitude.

The memory image is a parameter. Reset loads that image, so an instance runs a fixed program from address 00. Values reach the processor through a valid/ready input port and leave through a valid/ready output port. A halted flag reports that execution has stopped, and a fault flag marks a stop caused by an undefined instruction. A sticky overflow flag records any arithmetic result that fell outside -999..999.

Top module: `dec_acc_cpu`

## Requirements
- R1: After reset, `halted`, `fault`, `overflow`, `in_ready` and `out_valid` are 0, and execution starts with the word at address 00. The address latch is loaded only from the program counter or from the instruction's address field.
- R2: Word 901 raises `in_ready` and waits. On a cycle with `in_valid` and `in_ready` both high, the accumulator takes `in_neg`/`in_mag`. A magnitude of zero is always held as positive.
- R3: Word 902 raises `out_valid` with `out_neg`/`out_mag` equal to the accumulator. It keeps them steady until `out_ready` is seen high.
- R4: Opcode 3 (store) writes the accumulator magnitude to the addressed word, and the sign is dropped. Opcode 5 (load) sets the accumulator to that word as a positive value.
- R5: Opcode 1 (add) sets the accumulator to the accumulator plus the addressed word.
- R6: Opcode 2 (subtract) sets the accumulator to the accumulator minus the addressed word.
- R7: When an add or subtract result r has |r| > 999, the magnitude becomes |r| - 1000, the sign of r is kept (zero is positive), and `overflow` is set until reset.
- R8: Opcode 6 always jumps to the address field. Opcode 7 jumps when the accumulator is zero. Opcode 8 jumps when the accumulator is not negative. When no jump is taken, the next address in sequence follows, wrapping from 99 to 00.
- R9: Opcode 0 stops execution and sets `halted`. `halted` stays 1 until reset, and no further input or output handshake takes place.
- R10: Opcode 4, and opcode 9 with an address other than 01 or 02, set both `fault` and `halted`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input value offered |
| in_ready | output | 1 | Processor waiting on an input instruction |
| in_neg | input | 1 | Sign of offered value (1 = negative) |
| in_mag | input | 10 | Magnitude of offered value, 0..999 |
| out_valid | output | 1 | Output value presented |
| out_ready | input | 1 | Consumer accepts output |
| out_neg | output | 1 | Sign of presented value |
| out_mag | output | 10 | Magnitude of presented value |
| overflow | output | 1 | Sticky arithmetic overflow |
| halted | output | 1 | Execution stopped |
| fault | output | 1 | Stop caused by an undefined instruction |

## Verification
The only internal state the ports show is the accumulator and the program counter's path. A wrong accumulator, a mis-wrapped overflow, or a stored word that lost or kept the wrong value shows up on the next output handshake of the running program, within a few dozen cycles. A wrong branch decision changes the number of outputs per loop pass, or stops the run early, so a missed or extra handshake is detected on that pass. Halt and fault stops are visible on their flags within one instruction time.

// File: rtl/dec_cpu_pkg.sv
package dec_cpu_pkg;

  localparam int unsigned VAL_W   = 10;
  localparam int unsigned VAL_MAX = 999;
  localparam int unsigned VAL_MOD = 1000;
  localparam int unsigned FLD_MOD = 100;

  typedef enum logic [3:0] {
    ST_FPC  = 4'd0,
    ST_FRD  = 4'd1,
    ST_FIR  = 4'd2,
    ST_DEC  = 4'd3,
    ST_ORD  = 4'd4,
    ST_EXE  = 4'd5,
    ST_SMD  = 4'd6,
    ST_SWR  = 4'd7,
    ST_INP  = 4'd8,
    ST_OUTP = 4'd9,
    ST_INC  = 4'd10,
    ST_STOP = 4'd11
  } seq_state_e;

  typedef struct packed {
    logic mar_from_pc;
    logic mar_from_ir;
    logic mdr_from_mem;
    logic mdr_from_acc;
    logic ir_load;
    logic acc_from_in;
    logic acc_from_mdr;
    logic acc_from_alu;
    logic alu_sub;
    logic mem_write;
    logic pc_step;
    logic pc_jump;
    logic set_stop;
    logic set_fault;
  } xfer_ctl_t;

  function automatic logic [3:0] op_digit(input logic [VAL_W-1:0] w);
    return 4'(w / VAL_W'(FLD_MOD));
  endfunction

  function automatic logic [6:0] adr_field(input logic [VAL_W-1:0] w);
    return 7'(w % VAL_W'(FLD_MOD));
  endfunction

endpackage

// File: rtl/dec_word_store.sv
module dec_word_store #(
  parameter int unsigned DEPTH  = 100,
  parameter int unsigned W      = 10,
  parameter int unsigned ADDR_W = 7,
  parameter logic [DEPTH*W-1:0] IMAGE = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [W-1:0]      wdata,
  output logic [W-1:0]      rdata
);

  logic [W-1:0] cells [DEPTH];

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_cell
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cells[gi] <= IMAGE[gi*W +: W];
      end else if (wr_en && (addr == ADDR_W'(gi))) begin
        cells[gi] <= wdata;
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (int'(addr) < DEPTH) rdata = cells[addr];
  end

  assert_wr_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (int'(addr) < DEPTH));

endmodule

// File: rtl/dec_sm_alu.sv
module dec_sm_alu
  import dec_cpu_pkg::*;
(
  input  logic             a_neg,
  input  logic [VAL_W-1:0] a_mag,
  input  logic [VAL_W-1:0] b_mag,
  input  logic             sub,
  output logic             r_neg,
  output logic [VAL_W-1:0] r_mag,
  output logic             r_ovf
);

  localparam int unsigned SW = VAL_W + 2;

  logic signed [SW-1:0] sa, sb, sum, mag_abs, mag_wrap;

  always_comb begin
    sa       = a_neg ? -$signed({2'b00, a_mag}) : $signed({2'b00, a_mag});
    sb       = sub   ? -$signed({2'b00, b_mag}) : $signed({2'b00, b_mag});
    sum      = sa + sb;
    mag_abs  = sum[SW-1] ? -sum : sum;
    r_ovf    = mag_abs > SW'(VAL_MAX);
    mag_wrap = r_ovf ? (mag_abs - SW'(VAL_MOD)) : mag_abs;
    r_mag    = mag_wrap[VAL_W-1:0];
    r_neg    = sum[SW-1] && (r_mag != '0);
  end

endmodule

// File: rtl/dec_xfer_seq.sv
module dec_xfer_seq
  import dec_cpu_pkg::*;
(
  input  seq_state_e cur,
  input  logic [3:0] op,
  input  logic [6:0] adr,
  input  logic       acc_zero,
  input  logic       acc_neg,
  input  logic       in_valid,
  input  logic       out_ready,
  output seq_state_e nxt,
  output xfer_ctl_t  ctl
);

  always_comb begin
    nxt = cur;
    ctl = '0;
    unique case (cur)
      ST_FPC: begin ctl.mar_from_pc = 1'b1;  nxt = ST_FRD; end
      ST_FRD: begin ctl.mdr_from_mem = 1'b1; nxt = ST_FIR; end
      ST_FIR: begin ctl.ir_load = 1'b1;      nxt = ST_DEC; end
      ST_DEC: begin
        case (op)
          4'd0: begin ctl.set_stop = 1'b1; nxt = ST_STOP; end
          4'd1, 4'd2, 4'd5: begin ctl.mar_from_ir = 1'b1; nxt = ST_ORD; end
          4'd3: begin ctl.mar_from_ir = 1'b1; nxt = ST_SMD; end
          4'd6: begin ctl.pc_jump = 1'b1; nxt = ST_FPC; end
          4'd7: begin
            if (acc_zero) begin ctl.pc_jump = 1'b1; nxt = ST_FPC; end
            else nxt = ST_INC;
          end
          4'd8: begin
            if (!acc_neg) begin ctl.pc_jump = 1'b1; nxt = ST_FPC; end
            else nxt = ST_INC;
          end
          4'd9: begin
            if (adr == 7'd1)      nxt = ST_INP;
            else if (adr == 7'd2) nxt = ST_OUTP;
            else begin ctl.set_fault = 1'b1; ctl.set_stop = 1'b1; nxt = ST_STOP; end
          end
          default: begin ctl.set_fault = 1'b1; ctl.set_stop = 1'b1; nxt = ST_STOP; end
        endcase
      end
      ST_ORD: begin ctl.mdr_from_mem = 1'b1; nxt = ST_EXE; end
      ST_EXE: begin
        if (op == 4'd5) ctl.acc_from_mdr = 1'b1;
        else begin
          ctl.acc_from_alu = 1'b1;
          ctl.alu_sub      = (op == 4'd2);
        end
        nxt = ST_INC;
      end
      ST_SMD: begin ctl.mdr_from_acc = 1'b1; nxt = ST_SWR; end
      ST_SWR: begin ctl.mem_write = 1'b1;    nxt = ST_INC; end
      ST_INP: begin
        if (in_valid) begin ctl.acc_from_in = 1'b1; nxt = ST_INC; end
      end
      ST_OUTP: begin
        if (out_ready) nxt = ST_INC;
      end
      ST_INC:  begin ctl.pc_step = 1'b1; nxt = ST_FPC; end
      ST_STOP: nxt = ST_STOP;
      default: nxt = ST_STOP;
    endcase
  end

endmodule

// File: rtl/dec_acc_cpu.sv
module dec_acc_cpu
  import dec_cpu_pkg::*;
#(
  parameter int unsigned DEPTH = 100,
  parameter logic [DEPTH*VAL_W-1:0] IMAGE = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             in_neg,
  input  logic [VAL_W-1:0] in_mag,
  output logic             out_valid,
  input  logic             out_ready,
  output logic             out_neg,
  output logic [VAL_W-1:0] out_mag,
  output logic             overflow,
  output logic             halted,
  output logic             fault
);

  localparam int unsigned ADDR_W = $clog2(DEPTH);

  logic [1:0]        rst_pipe;
  logic              rst_ns;
  seq_state_e        st_q, st_d;
  xfer_ctl_t         ctl;
  logic [ADDR_W-1:0] pc_q, mar_q;
  logic [VAL_W-1:0]  mdr_q, ir_q, mem_rdata, acc_mag_q, alu_mag, in_wrap;
  logic              acc_neg_q, alu_neg, alu_ovf;
  logic              ovf_q, stop_q, fault_q;
  logic [3:0]        op;
  logic [6:0]        adr;

  // reset: asserted at once, released on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_ns = rst_pipe[1];

  assign op      = op_digit(ir_q);
  assign adr     = adr_field(ir_q);
  assign in_wrap = VAL_W'(in_mag % VAL_W'(VAL_MOD));

  dec_xfer_seq u_seq (
    .cur      (st_q),
    .op       (op),
    .adr      (adr),
    .acc_zero (acc_mag_q == '0),
    .acc_neg  (acc_neg_q),
    .in_valid (in_valid),
    .out_ready(out_ready),
    .nxt      (st_d),
    .ctl      (ctl)
  );

  dec_sm_alu u_alu (
    .a_neg(acc_neg_q),
    .a_mag(acc_mag_q),
    .b_mag(mdr_q),
    .sub  (ctl.alu_sub),
    .r_neg(alu_neg),
    .r_mag(alu_mag),
    .r_ovf(alu_ovf)
  );

  dec_word_store #(
    .DEPTH (DEPTH),
    .W     (VAL_W),
    .ADDR_W(ADDR_W),
    .IMAGE (IMAGE)
  ) u_mem (
    .clk  (clk),
    .rst_n(rst_ns),
    .wr_en(ctl.mem_write),
    .addr (mar_q),
    .wdata(mdr_q),
    .rdata(mem_rdata)
  );

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) st_q <= ST_FPC;
    else         st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns)          pc_q <= '0;
    else if (ctl.pc_jump) pc_q <= ADDR_W'(adr);
    else if (ctl.pc_step) pc_q <= (int'(pc_q) == DEPTH-1) ? '0 : pc_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns)              mar_q <= '0;
    else if (ctl.mar_from_pc) mar_q <= pc_q;
    else if (ctl.mar_from_ir) mar_q <= ADDR_W'(adr);
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns)               mdr_q <= '0;
    else if (ctl.mdr_from_mem) mdr_q <= mem_rdata;
    else if (ctl.mdr_from_acc) mdr_q <= acc_mag_q;
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns)          ir_q <= '0;
    else if (ctl.ir_load) ir_q <= mdr_q;
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      acc_neg_q <= 1'b0;
      acc_mag_q <= '0;
    end else if (ctl.acc_from_in) begin
      acc_neg_q <= in_neg && (in_wrap != '0);
      acc_mag_q <= in_wrap;
    end else if (ctl.acc_from_mdr) begin
      acc_neg_q <= 1'b0;
      acc_mag_q <= mdr_q;
    end else if (ctl.acc_from_alu) begin
      acc_neg_q <= alu_neg;
      acc_mag_q <= alu_mag;
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns)                           ovf_q <= 1'b0;
    else if (ctl.acc_from_alu && alu_ovf)  ovf_q <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      stop_q  <= 1'b0;
      fault_q <= 1'b0;
    end else begin
      if (ctl.set_stop)  stop_q  <= 1'b1;
      if (ctl.set_fault) fault_q <= 1'b1;
    end
  end

  assign in_ready  = (st_q == ST_INP);
  assign out_valid = (st_q == ST_OUTP);
  assign out_neg   = acc_neg_q;
  assign out_mag   = acc_mag_q;
  assign overflow  = ovf_q;
  assign halted    = stop_q;
  assign fault     = fault_q;

  assert_mar_hold_R1: assert property (@(posedge clk) disable iff (!rst_ns)
    (st_q != ST_FPC && st_q != ST_DEC) |=> $stable(mar_q));
  assert_io_excl_R2: assert property (@(posedge clk) disable iff (!rst_ns)
    !(in_ready && out_valid));
  assert_no_neg_zero_R2: assert property (@(posedge clk) disable iff (!rst_ns)
    acc_neg_q |-> (acc_mag_q != '0));
  assert_out_hold_R3: assert property (@(posedge clk) disable iff (!rst_ns)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_mag) && $stable(out_neg)));
  assert_mag_range_R7: assert property (@(posedge clk) disable iff (!rst_ns)
    acc_mag_q <= VAL_W'(VAL_MAX));
  assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (!rst_ns)
    overflow |=> overflow);
  assert_halt_sticky_R9: assert property (@(posedge clk) disable iff (!rst_ns)
    halted |=> (halted && !in_ready && !out_valid));
  assert_fault_stops_R10: assert property (@(posedge clk) disable iff (!rst_ns)
    fault |-> halted);

endmodule

// File: tb/dec_acc_cpu_tb.sv
`timescale 1ns/1ps
module dec_acc_cpu_tb;

  localparam int DEPTH = 100;
  localparam int IW    = DEPTH * 10;

  function automatic logic [IW-1:0] put(input logic [IW-1:0] img, input int a, input int w);
    img[a*10 +: 10] = 10'(w);
    return img;
  endfunction

  function automatic logic [IW-1:0] main_image();
    logic [IW-1:0] m = '0;
    m = put(m, 0, 901);  m = put(m, 1, 715);  m = put(m, 2, 902);
    m = put(m, 3, 390);  m = put(m, 4, 901);  m = put(m, 5, 391);
    m = put(m, 6, 291);  m = put(m, 7, 902);  m = put(m, 8, 590);
    m = put(m, 9, 191);  m = put(m, 10, 902); m = put(m, 11, 291);
    m = put(m, 12, 814); m = put(m, 13, 902); m = put(m, 14, 600);
    m = put(m, 15, 0);
    return m;
  endfunction

  localparam logic [IW-1:0] MAIN_IMG = main_image();
  localparam logic [IW-1:0] BAD4_IMG = put('0, 0, 450);
  localparam logic [IW-1:0] BAD9_IMG = put('0, 0, 950);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_neg = 1'b0, out_ready = 1'b0;
  logic [9:0] in_mag = '0;
  logic in_ready, out_valid, out_neg, overflow, halted, fault;
  logic [9:0] out_mag;
  logic e4_ir, e4_ov, e4_on, e4_of, e4_h, e4_f;
  logic e9_ir, e9_ov, e9_on, e9_of, e9_h, e9_f;
  logic [9:0] e4_om, e9_om;

  int total = 0, bad = 0;
  bit done = 0;
  bit m_ovf = 0;

  always #2.5 clk = ~clk;

  dec_acc_cpu #(.DEPTH(DEPTH), .IMAGE(MAIN_IMG)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_neg(in_neg), .in_mag(in_mag), .out_valid(out_valid), .out_ready(out_ready),
    .out_neg(out_neg), .out_mag(out_mag), .overflow(overflow), .halted(halted), .fault(fault));

  dec_acc_cpu #(.DEPTH(DEPTH), .IMAGE(BAD4_IMG)) u_err4 (
    .clk(clk), .rst_n(rst_n), .in_valid(1'b0), .in_ready(e4_ir),
    .in_neg(1'b0), .in_mag(10'd0), .out_valid(e4_ov), .out_ready(1'b1),
    .out_neg(e4_on), .out_mag(e4_om), .overflow(e4_of), .halted(e4_h), .fault(e4_f));

  dec_acc_cpu #(.DEPTH(DEPTH), .IMAGE(BAD9_IMG)) u_err9 (
    .clk(clk), .rst_n(rst_n), .in_valid(1'b0), .in_ready(e9_ir),
    .in_neg(1'b0), .in_mag(10'd0), .out_valid(e9_ov), .out_ready(1'b1),
    .out_neg(e9_on), .out_mag(e9_om), .overflow(e9_of), .halted(e9_h), .fault(e9_f));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // signed-magnitude model of add/subtract with wrap (R5, R6, R7)
  function automatic void sm_op(input bit an, input int am, input int bm, input bit sub,
                                output bit rn, output int rm);
    int s, ab;
    s  = (an ? -am : am) + (sub ? -bm : bm);
    ab = (s < 0) ? -s : s;
    if (ab > 999) begin
      m_ovf = 1;
      rm = ab - 1000;
    end else rm = ab;
    rn = (s < 0) && (rm != 0);
  endfunction

  task automatic send(input bit n, input int m);
    @(negedge clk);
    in_valid = 1'b1; in_neg = n; in_mag = 10'(m);
    forever begin
      if (in_ready) begin
        @(negedge clk);
        break;
      end
      @(negedge clk);
    end
    in_valid = 1'b0;
  endtask

  task automatic recv(input bit en, input int em, input string req);
    int wait_n;
    do @(negedge clk); while (!out_valid);
    wait_n = int'($urandom % 3);
    for (int k = 0; k < wait_n; k++) @(negedge clk);
    check(out_valid && out_mag == 10'(em), {req, " R3 magnitude"}, int'(out_mag), em);
    check(out_neg == en, {req, " sign"}, int'(out_neg), int'(en));
    check(overflow == m_ovf, "R7 sticky overflow", int'(overflow), int'(m_ovf));
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  task automatic pass_pair(input bit an, input int am, input bit bn, input int bm);
    bit rn; int rm;
    bit bnn = bn && (bm != 0);
    send(an, am);
    recv(an && (am != 0), am, "R2 echo, R8 zero-branch not taken");
    send(bn, bm);
    sm_op(bnn, bm, bm, 1'b1, rn, rm);
    recv(rn, rm, "R6 subtract stored word");
    sm_op(1'b0, am, bm, 1'b0, rn, rm);
    recv(rn, rm, "R4 load/store, R5 add");
    sm_op(rn, rm, bm, 1'b1, rn, rm);
    if (rn) recv(rn, rm, "R8 non-negative branch not taken, R6");
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(!halted && !fault && !overflow, "R1 reset flags", int'({halted, fault, overflow}), 0);
    check(!out_valid, "R1 reset out_valid", int'(out_valid), 0);
    repeat (6) @(negedge clk);
    check(in_ready, "R1 start at 00 reaches input", int'(in_ready), 1);
    check(e4_h && e4_f, "R10 opcode 4 faults", int'({e4_h, e4_f}), 3);
    check(e9_h && e9_f, "R10 bad 9xx faults", int'({e9_h, e9_f}), 3);
    check(!e4_ov && !e9_ov, "R10 no output after fault", int'({e4_ov, e9_ov}), 0);

    pass_pair(0, 999, 0, 999);
    pass_pair(1, 999, 1, 999);
    pass_pair(1, 5, 1, 0);
    pass_pair(0, 1, 1, 500);
    pass_pair(1, 500, 0, 499);
    pass_pair(0, 7, 0, 999);
    for (int i = 0; i < 24; i++) begin
      pass_pair(1'($urandom), int'($urandom % 999) + 1, 1'($urandom), int'($urandom % 1000));
    end

    send(1, 0);
    repeat (30) @(negedge clk);
    check(halted && !fault, "R9 halt via R8 zero-branch", int'({halted, fault}), 2);
    in_valid = 1'b1;
    repeat (10) @(negedge clk);
    check(halted && !in_ready && !out_valid, "R9 stays halted, no handshake",
          int'({halted, in_ready, out_valid}), 4);
    in_valid = 1'b0;

    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule